// File: doc/BRIEF.md
# Flash Command Interface

This block is the host-side front end of a parallel flash part. The host drives active-low chip enable, write enable and output enable, an address bus and a write data bus, all without reference to the block's clock. The block brings these onto its system clock, recognises write cycles, and holds on to the address and data of each one. A write cycle may be framed by either enable. The address is taken when the second of the two enables goes low. The data is taken when the first of the two goes high again.

Each completed write feeds a small command decoder. Programming takes two writes: a set-up code, then a write whose address and data are the target byte. Erasure takes a set-up code confirmed by the same code a second time. Accepted operations leave as one-cycle start pulses to the sequencer, along with the latched operands. While an operation runs, reads return the sequencer's status word rather than array contents, and the only command accepted is reset. Reset aborts the running operation.

Top module: `flash_cmd_if`

## Requirements
- R1: The address of a write cycle is the value on the address bus when the later of chip enable and write enable falls. Address changes before that edge or after it do not matter.
- R2: The data of a write cycle is the value on the data bus when the earlier of the two enables rises. Data changes after that edge do not matter.
- R3: When idle, a write of 0x40 (low eight data bits) arms programming. The next write produces a one-cycle `prog_start` pulse, with `seq_addr` and `seq_data` holding that write's address and data, unless its data is 0xFF.
- R4: When idle, a write of 0x20 arms erasure. A following write of 0x20 produces a one-cycle `erase_start` pulse. A following write of any other value cancels erasure, starts nothing and leaves the decoder idle.
- R5: A write of 0xFF, or of any value other than 0x40 or 0x20, while idle starts nothing. A write of 0xFF while programming is armed cancels it. In both cases the next write is decoded as a fresh command.
- R6: `bus_rdata_oe` is high only when chip enable and output enable are both low and write enable is high.
- R7: From a start pulse until `seq_done` is seen, reads return `seq_status`. At all other times, reads return `arr_rdata` for the address on the bus. `arr_addr` follows that address.
- R8: While an operation runs, every write except 0xFF is ignored, so a set-up code written then does not arm anything. A 0xFF write pulses `seq_abort` for one cycle and ends the operation. A 0xFF write while idle raises no abort.
- R9: Each control input passes through `SYNC_STAGES` flip-flops. A start pulse appears on the (`SYNC_STAGES`+1)-th rising clock edge after the enable edge that ends the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low, unsynchronised |
| we_n | input | 1 | Write enable, active low, unsynchronised |
| oe_n | input | 1 | Output enable, active low, unsynchronised |
| bus_addr | input | ADDR_W | Host address bus |
| bus_wdata | input | DATA_W | Host write data bus |
| bus_rdata | output | DATA_W | Read data to the host |
| bus_rdata_oe | output | 1 | Drive enable for `bus_rdata` |
| arr_addr | output | ADDR_W | Synchronised read address to the array |
| arr_rdata | input | DATA_W | Array contents at `arr_addr` |
| seq_status | input | DATA_W | Status word from the sequencer |
| seq_done | input | 1 | One-cycle pulse: operation finished |
| prog_start | output | 1 | One-cycle pulse: start programming |
| erase_start | output | 1 | One-cycle pulse: start erasure |
| seq_abort | output | 1 | One-cycle pulse: abort the running operation |
| seq_addr | output | ADDR_W | Latched program address |
| seq_data | output | DATA_W | Latched program data |

## Verification
The assertions assume the host keeps output enable high during write cycles. They also assume the sequencer raises `seq_done` only after a start pulse. The bench keeps within both assumptions: its write task never lowers output enable, and it pulses `seq_done` only while its own model counts an operation as running. Addresses and data are held for several clocks around each enable edge, so the synchronised buses and controls stay aligned. Random runs vary which enable opens and which enable closes each write. Between edges, the bench puts inverted values on the buses, so a capture on the wrong edge shows up in the operands.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;

   // Decoder progress through a two-write command
   typedef enum logic [1:0] {
      CS_IDLE      = 2'd0,
      CS_PROG_ARM  = 2'd1,
      CS_ERASE_ARM = 2'd2
   } cmd_state_e;

   // Command codes, compared against the low byte of a write
   localparam logic [7:0] CODE_PROG_SETUP = 8'h40;
   localparam logic [7:0] CODE_ERASE      = 8'h20;
   localparam logic [7:0] CODE_RESET      = 8'hFF;

endpackage

// File: rtl/fcmd_sync.sv
`timescale 1ns/1ps
module fcmd_sync #(
   parameter int unsigned     WIDTH   = 1,
   parameter int unsigned     STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic [WIDTH-1:0] r;
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= g_stage[i-1].r;
         end
      end
   end

   assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/fcmd_wr_capture.sv
`timescale 1ns/1ps
module fcmd_wr_capture #(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_s,
   input  logic              we_s,
   input  logic [ADDR_W-1:0] addr_s,
   input  logic [DATA_W-1:0] data_s,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              wr_stb
);

   logic wr_act;
   logic wr_act_q;
   logic [ADDR_W-1:0] addr_q;

   // Write window is open only while both enables are low
   assign wr_act = ~ce_s & ~we_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_act_q <= 1'b0;
         addr_q   <= '0;
      end else begin
         wr_act_q <= wr_act;
         // window opens on the later falling enable
         if (wr_act && !wr_act_q) addr_q <= addr_s;
      end
   end

   // window closes on the earlier rising enable: data taken now
   assign wr_stb  = wr_act_q & ~wr_act;
   assign wr_data = data_s;
   assign wr_addr = addr_q;

endmodule

// File: rtl/fcmd_decoder.sv
`timescale 1ns/1ps
module fcmd_decoder
   import flash_cmd_pkg::*;
#(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              seq_done,
   output logic              prog_start,
   output logic              erase_start,
   output logic              seq_abort,
   output logic [ADDR_W-1:0] seq_addr,
   output logic [DATA_W-1:0] seq_data,
   output logic              op_run
);

   cmd_state_e state_q, state_d;
   logic       run_d, prog_d, erase_d, abort_d;
   logic [7:0] code;

   assign code = wr_data[7:0];

   always_comb begin
      state_d = state_q;
      run_d   = op_run & ~seq_done;
      prog_d  = 1'b0;
      erase_d = 1'b0;
      abort_d = 1'b0;
      if (wr_stb) begin
         if (op_run) begin
            // only reset gets through while the sequencer works
            if (code == CODE_RESET) begin
               abort_d = 1'b1;
               run_d   = 1'b0;
               state_d = CS_IDLE;
            end
         end else begin
            unique case (state_q)
               CS_IDLE: begin
                  if (code == CODE_PROG_SETUP)  state_d = CS_PROG_ARM;
                  else if (code == CODE_ERASE)  state_d = CS_ERASE_ARM;
                  else                          state_d = CS_IDLE;
               end
               CS_PROG_ARM: begin
                  state_d = CS_IDLE;
                  if (code != CODE_RESET) begin
                     prog_d = 1'b1;
                     run_d  = 1'b1;
                  end
               end
               CS_ERASE_ARM: begin
                  state_d = CS_IDLE;
                  if (code == CODE_ERASE) begin
                     erase_d = 1'b1;
                     run_d   = 1'b1;
                  end
               end
               default: state_d = CS_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= CS_IDLE;
         op_run      <= 1'b0;
         prog_start  <= 1'b0;
         erase_start <= 1'b0;
         seq_abort   <= 1'b0;
         seq_addr    <= '0;
         seq_data    <= '0;
      end else begin
         state_q     <= state_d;
         op_run      <= run_d;
         prog_start  <= prog_d;
         erase_start <= erase_d;
         seq_abort   <= abort_d;
         if (prog_d) begin
            seq_addr <= wr_addr;
            seq_data <= wr_data;
         end
      end
   end

endmodule

// File: rtl/fcmd_read_path.sv
`timescale 1ns/1ps
module fcmd_read_path #(
   parameter int unsigned DATA_W = 8,
   parameter bit          RD_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_s,
   input  logic              oe_s,
   input  logic              we_s,
   input  logic              op_run,
   input  logic [DATA_W-1:0] seq_status,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_oe
);

   logic [DATA_W-1:0] sel_data;
   logic              sel_oe;

   assign sel_data = op_run ? seq_status : arr_rdata;
   assign sel_oe   = ~ce_s & ~oe_s & we_s;

   if (RD_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_data <= '0;
            rd_oe   <= 1'b0;
         end else begin
            rd_data <= sel_data;
            rd_oe   <= sel_oe;
         end
      end
   end else begin : g_comb
      assign rd_data = sel_data;
      assign rd_oe   = sel_oe;
   end

endmodule

// File: rtl/flash_cmd_if.sv
`timescale 1ns/1ps
module flash_cmd_if #(
   parameter int unsigned ADDR_W      = 15,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RD_REG      = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rdata_oe,
   output logic [ADDR_W-1:0] arr_addr,
   input  logic [DATA_W-1:0] arr_rdata,
   input  logic [DATA_W-1:0] seq_status,
   input  logic              seq_done,
   output logic              prog_start,
   output logic              erase_start,
   output logic              seq_abort,
   output logic [ADDR_W-1:0] seq_addr,
   output logic [DATA_W-1:0] seq_data
);

   localparam int unsigned BUS_W = ADDR_W + DATA_W;

   if (ADDR_W < 1) begin : g_bad_addr
      $error("flash_cmd_if: ADDR_W must be at least 1");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("flash_cmd_if: DATA_W must hold an 8-bit command");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("flash_cmd_if: SYNC_STAGES must be 2 or more");
   end

   logic              ce_s, we_s, oe_s;
   logic [ADDR_W-1:0] addr_s;
   logic [DATA_W-1:0] data_s;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic              wr_stb;
   logic              op_run;

   fcmd_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b111)
   ) i_ctl_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ce_n, we_n, oe_n}),
      .q     ({ce_s, we_s, oe_s})
   );

   // buses ride the same depth so they stay aligned with the controls
   fcmd_sync #(
      .WIDTH   (BUS_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL ({BUS_W{1'b0}})
   ) i_bus_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({bus_addr, bus_wdata}),
      .q     ({addr_s, data_s})
   );

   fcmd_wr_capture #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_wr_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .ce_s    (ce_s),
      .we_s    (we_s),
      .addr_s  (addr_s),
      .data_s  (data_s),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .wr_stb  (wr_stb)
   );

   fcmd_decoder #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) i_decoder (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_stb      (wr_stb),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .seq_done    (seq_done),
      .prog_start  (prog_start),
      .erase_start (erase_start),
      .seq_abort   (seq_abort),
      .seq_addr    (seq_addr),
      .seq_data    (seq_data),
      .op_run      (op_run)
   );

   fcmd_read_path #(
      .DATA_W (DATA_W),
      .RD_REG (RD_REG)
   ) i_read_path (
      .clk        (clk),
      .rst_n      (rst_n),
      .ce_s       (ce_s),
      .oe_s       (oe_s),
      .we_s       (we_s),
      .op_run     (op_run),
      .seq_status (seq_status),
      .arr_rdata  (arr_rdata),
      .rd_data    (bus_rdata),
      .rd_oe      (bus_rdata_oe)
   );

   assign arr_addr = addr_s;

endmodule

// File: rtl/flash_cmd_if_chk.sv
`timescale 1ns/1ps
module flash_cmd_if_chk #(
   parameter bit RD_REG = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic ce_s,
   input logic oe_s,
   input logic we_s,
   input logic op_run,
   input logic prog_start,
   input logic erase_start,
   input logic seq_abort,
   input logic rd_oe
);

   // R3: program start lasts one cycle
   a_r3_prog_single: assert property (@(posedge clk) disable iff (!rst_n)
      prog_start |=> !prog_start);

   // R4: erase start lasts one cycle and never coincides with program start
   a_r4_erase_single: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |=> !erase_start);
   a_r4_no_dual_start: assert property (@(posedge clk) disable iff (!rst_n)
      !(prog_start && erase_start));

   // R7: an accepted start leaves the block in the running state
   a_r7_run_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_start || erase_start) |-> op_run);

   // R8: nothing starts while an operation was already running
   a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $past(op_run) |-> !(prog_start || erase_start));

   // R8: abort only ends a running operation
   a_r8_abort_when_run: assert property (@(posedge clk) disable iff (!rst_n)
      seq_abort |-> ($past(op_run) && !op_run));

   // R6: read drive needs both enables low and no write
   if (RD_REG) begin : g_oe_reg
      a_r6_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
         rd_oe |-> $past(!ce_s && !oe_s && we_s));
   end else begin : g_oe_comb
      a_r6_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
         rd_oe |-> (!ce_s && !oe_s && we_s));
   end

endmodule

bind flash_cmd_if flash_cmd_if_chk #(.RD_REG(RD_REG)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ce_s        (ce_s),
   .oe_s        (oe_s),
   .we_s        (we_s),
   .op_run      (op_run),
   .prog_start  (prog_start),
   .erase_start (erase_start),
   .seq_abort   (seq_abort),
   .rd_oe       (bus_rdata_oe)
);

// File: tb/test_flash_cmd_if.sv
`timescale 1ns/1ps
module test_flash_cmd_if;

   localparam int AW = 8;
   localparam int DW = 8;
   localparam int SS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          bus_rdata_oe;
   logic [AW-1:0] arr_addr;
   logic [DW-1:0] arr_rdata;
   logic [DW-1:0] seq_status = 8'hA5;
   logic          seq_done = 1'b0;
   logic          prog_start, erase_start, seq_abort;
   logic [AW-1:0] seq_addr;
   logic [DW-1:0] seq_data;

   always #2.5 clk = ~clk;

   function automatic logic [DW-1:0] arr_fn(input logic [AW-1:0] a);
      logic [15:0] t;
      t = {8'h00, a} * 16'd37;
      return t[7:0] ^ 8'h5A;
   endfunction

   assign arr_rdata = arr_fn(arr_addr);

   flash_cmd_if #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SS), .RD_REG(1'b1)) i_flash_cmd_if (
      .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .we_n (we_n), .oe_n (oe_n),
      .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .bus_rdata_oe (bus_rdata_oe), .arr_addr (arr_addr), .arr_rdata (arr_rdata),
      .seq_status (seq_status), .seq_done (seq_done), .prog_start (prog_start),
      .erase_start (erase_start), .seq_abort (seq_abort), .seq_addr (seq_addr),
      .seq_data (seq_data)
   );

   int ntests = 0, nfail = 0;
   int cyc = 0;
   int prog_cnt = 0, erase_cnt = 0, abort_cnt = 0;
   int pulse_cyc = 0, rise_cyc = 0;
   logic [AW-1:0] got_addr;
   logic [DW-1:0] got_data;
   bit finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (prog_start)  begin prog_cnt++;  pulse_cyc = cyc; got_addr = seq_addr; got_data = seq_data; end
      if (erase_start) begin erase_cnt++; pulse_cyc = cyc; end
      if (seq_abort)   abort_cnt++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      ntests++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   // one host write; ce_first: chip enable opens, we_rise_first: write enable closes
   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                     input bit ce_first, input bit we_rise_first);
      bus_addr = ~a; bus_wdata = ~d;
      if (ce_first) ce_n = 1'b0; else we_n = 1'b0;
      wt(3); bus_addr = a;
      wt(3);
      if (ce_first) we_n = 1'b0; else ce_n = 1'b0;
      wt(3); bus_addr = ~a; bus_wdata = d;
      wt(3);
      rise_cyc = cyc;
      if (we_rise_first) we_n = 1'b1; else ce_n = 1'b1;
      wt(3); bus_wdata = ~d;
      wt(2); ce_n = 1'b1; we_n = 1'b1;
      wt(4);
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic oe);
      bus_addr = a; ce_n = 1'b0; oe_n = 1'b0;
      wt(5); d = bus_rdata; oe = bus_rdata_oe;
      ce_n = 1'b1; oe_n = 1'b1;
      wt(3);
   endtask

   task automatic done_pulse();
      seq_done = 1'b1; wt(1); seq_done = 1'b0; wt(2);
   endtask

   // bench model of the command rules
   int m_state = 0; bit m_run = 1'b0;
   int e_prog = 0, e_erase = 0, e_abort = 0;
   logic [AW-1:0] e_addr; logic [DW-1:0] e_data;

   task automatic model_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
      if (m_run) begin
         if (d == 8'hFF) begin e_abort++; m_run = 1'b0; m_state = 0; end
      end else begin
         case (m_state)
            0: m_state = (d == 8'h40) ? 1 : (d == 8'h20) ? 2 : 0;
            1: begin
               if (d != 8'hFF) begin e_prog++; e_addr = a; e_data = d; m_run = 1'b1; end
               m_state = 0;
            end
            default: begin
               if (d == 8'h20) begin e_erase++; m_run = 1'b1; end
               m_state = 0;
            end
         endcase
      end
   endtask

   task automatic mwr(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit cf, input bit wf);
      wr(a, d, cf, wf);
      model_wr(a, d);
   endtask

   task automatic cmp_counts(input string tag);
      chk(prog_cnt == e_prog, {tag, " R3 program pulses"}, prog_cnt, e_prog);
      chk(erase_cnt == e_erase, {tag, " R4 erase pulses"}, erase_cnt, e_erase);
      chk(abort_cnt == e_abort, {tag, " R8 abort pulses"}, abort_cnt, e_abort);
   endtask

   initial begin
      logic [DW-1:0] d;
      logic oe;
      int unsigned seed;
      seed = $urandom(32'h1F2E3D4C);

      // reset state
      wt(5);
      chk(bus_rdata_oe == 1'b0, "R6 reset drive", bus_rdata_oe, 0);
      chk({prog_start, erase_start, seq_abort} == 3'b000, "R3 reset pulses",
          {prog_start, erase_start, seq_abort}, 0);
      rst_n = 1'b1;
      wt(3);

      // R6: drive gating
      bus_addr = 8'h11; ce_n = 1'b1; oe_n = 1'b0; wt(5);
      chk(bus_rdata_oe == 1'b0, "R6 oe without ce", bus_rdata_oe, 0);
      ce_n = 1'b0; oe_n = 1'b1; wt(5);
      chk(bus_rdata_oe == 1'b0, "R6 ce without oe", bus_rdata_oe, 0);
      ce_n = 1'b1; wt(3);
      rd(8'h2B, d, oe);
      chk(oe == 1'b1, "R6 both enables", oe, 1);
      chk(d == arr_fn(8'h2B), "R7 array read idle", d, arr_fn(8'h2B));
      chk(arr_addr == 8'h2B, "R7 array address", arr_addr, 8'h2B);

      // R3 with R1, R2, R9
      mwr(8'h00, 8'h40, 1'b1, 1'b1);
      chk(prog_cnt == 0, "R3 set-up alone", prog_cnt, 0);
      mwr(8'h3C, 8'h96, 1'b0, 1'b0);
      chk(prog_cnt == 1, "R3 program pulse", prog_cnt, 1);
      chk(got_addr == 8'h3C, "R1 later falling edge address", got_addr, 8'h3C);
      chk(got_data == 8'h96, "R2 earlier rising edge data", got_data, 8'h96);
      chk(pulse_cyc - rise_cyc == SS + 1, "R9 start latency", pulse_cyc - rise_cyc, SS + 1);
      rd(8'h3C, d, oe);
      chk(d == 8'hA5, "R7 status while running", d, 8'hA5);
      done_pulse(); m_run = 1'b0;
      rd(8'h3C, d, oe);
      chk(d == arr_fn(8'h3C), "R7 array after done", d, arr_fn(8'h3C));

      // R4 erase and cancel
      mwr(8'h01, 8'h20, 1'b1, 1'b0);
      mwr(8'h02, 8'h20, 1'b0, 1'b1);
      chk(erase_cnt == 1, "R4 erase pulse", erase_cnt, 1);
      done_pulse(); m_run = 1'b0;
      mwr(8'h03, 8'h20, 1'b1, 1'b1);
      mwr(8'h04, 8'h33, 1'b1, 1'b1);
      mwr(8'h05, 8'h77, 1'b1, 1'b1);
      chk(erase_cnt == 1 && prog_cnt == 1, "R4 cancelled erase", erase_cnt + prog_cnt, 2);

      // R5 reset cancels program set-up, unknown code ignored
      mwr(8'h06, 8'h40, 1'b0, 1'b1);
      mwr(8'h07, 8'hFF, 1'b0, 1'b1);
      mwr(8'h08, 8'h12, 1'b0, 1'b1);
      mwr(8'h09, 8'h99, 1'b1, 1'b0);
      mwr(8'h0A, 8'h55, 1'b1, 1'b0);
      chk(prog_cnt == 1, "R5 no program after reset/unknown", prog_cnt, 1);
      chk(abort_cnt == 0, "R8 idle reset no abort", abort_cnt, 0);

      // R8 busy: writes ignored, reset aborts
      mwr(8'h10, 8'h40, 1'b1, 1'b1);
      mwr(8'h11, 8'hC3, 1'b1, 1'b1);
      mwr(8'h12, 8'h40, 1'b1, 1'b1);
      mwr(8'h13, 8'h20, 1'b1, 1'b1);
      mwr(8'h14, 8'h20, 1'b1, 1'b1);
      chk(prog_cnt == 2 && erase_cnt == 1, "R8 busy writes ignored", prog_cnt * 16 + erase_cnt, 8'h21);
      done_pulse(); m_run = 1'b0;
      mwr(8'h15, 8'h5E, 1'b1, 1'b1);
      chk(prog_cnt == 2, "R8 busy set-up not armed", prog_cnt, 2);
      mwr(8'h16, 8'h40, 1'b1, 1'b1);
      mwr(8'h17, 8'h0F, 1'b0, 1'b0);
      mwr(8'h18, 8'hFF, 1'b0, 1'b0);
      chk(abort_cnt == 1, "R8 abort pulse", abort_cnt, 1);
      rd(8'h44, d, oe);
      chk(d == arr_fn(8'h44), "R8 array after abort", d, arr_fn(8'h44));
      cmp_counts("directed");

      // random mix
      for (int i = 0; i < 150; i++) begin
         logic [DW-1:0] rd_v;
         logic [AW-1:0] ra;
         int sel;
         sel = $urandom % 4;
         ra = AW'($urandom);
         rd_v = (sel == 0) ? 8'h40 : (sel == 1) ? 8'h20 : (sel == 2) ? 8'hFF : DW'($urandom);
         mwr(ra, rd_v, 1'($urandom), 1'($urandom));
         cmp_counts("random");
         if (e_prog > 0) begin
            chk(got_addr == e_addr, "random R1 operand address", got_addr, e_addr);
            chk(got_data == e_data, "random R2 operand data", got_data, e_data);
         end
         if (($urandom % 4) == 0) begin
            logic [AW-1:0] qa;
            qa = AW'($urandom);
            rd(qa, d, oe);
            chk(d == (m_run ? 8'hA5 : arr_fn(qa)), "random R7 read", d, m_run ? 8'hA5 : arr_fn(qa));
         end
         if (m_run && ($urandom % 3) == 0) begin
            done_pulse(); m_run = 1'b0;
         end
      end

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         ntests++; nfail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("[TB] %0d tests run, %0d failed", ntests, nfail);
         $finish;
      end
   end

endmodule